// File: doc/BRIEF.md
# SDRAM Command Decoder and Bank Tracker

This block watches the control pins of a four-bank single-data-rate SDRAM from the device side. On every rising clock edge it samples the clock enable, the four active-low strobes, the bank-select bits and the address bus. It names the command of that cycle and checks it against the state of the addressed bank and of the whole device. Any command that is not allowed at that moment is flagged and has no effect.

Each bank is tracked as idle, open (a row is active) or recovering from an auto-precharge. The block keeps the mode register, follows the running data burst so it can tell clock suspend from power down, and reports the device power state. It is meant as the protocol core of a memory model, or as a monitor placed beside a controller. Data transfer, refresh timing and electrical behaviour are not modelled.

All outputs are registered. The report for a command sampled at one edge is visible from that edge on.

Top module: `sdram_cmd_tracker`

## Requirements
- R1: With CKE high in both the previous and the current cycle, the strobes {cs_n,ras_n,cas_n,we_n} decode as follows: 0011 activate (code 2), 0010 precharge (5, or 6 when address bit 10 is high), 0100 write (4), 0101 read (3), 0000 mode register set (9), 0001 auto refresh (7), 0110 burst stop (10), 0111 NOP (1), and cs_n high deselect (0). `cmd_o` carries the code.
- R2: Activate is accepted only by an idle bank. Read and write are accepted only by an open bank. Any other case raises `cmd_illegal_o` for that one report and changes no bank, mode or burst state.
- R3: Precharge with address bit 10 low closes only the bank on `ba`. With bit 10 high it closes every bank. It is rejected if the target bank, or for precharge-all any bank, is recovering.
- R4: A write with address bit 10 high puts its bank into recovery (bank code 2) for (write burst − 1) + TWR + TRP edges. A read with bit 10 high does so for (read burst − 1) + TRP edges. After that the bank is idle (code 0). Every command to the bank during recovery is rejected. Bank i is reported on `bank_state_o[2i+1:2i]` (0 idle, 1 open, 2 recovering).
- R5: When the burst that applies is full page, the auto-precharge request is ignored and the bank stays open.
- R6: A mode register set is accepted only while all banks are idle. It loads {ba, addr} into `mode_o`. On the edge that follows an accepted set, activate, read, write, refresh and another mode set are rejected.
- R7: The refresh encoding with CKE high in the previous cycle and low now enters self refresh (code 8; `pwr_o` = 1), provided all banks are idle. Self refresh ends at the first edge where CKE is sampled high.
- R8: CKE falling with any other command enters clock suspend (`pwr_o` = 3) if a burst is running, and power down (`pwr_o` = 2) otherwise. While in a low-power state nothing is decoded (code 11, never illegal). The first edge where CKE is sampled high returns to normal (`pwr_o` = 0).
- R9: The burst length comes from mode bits [2:0]: 0→1, 1→2, 2→4, 3→8, 7→full page, other values→1. Mode bit 9 sets the write burst to 1. `burst_busy_o` is high for the burst length minus one edges after an accepted read or write. A full-page burst keeps it high until a burst stop. The burst count does not advance while CKE is low or was low in the previous cycle.
- R10: During reset all outputs are zero: deselect, no flag, normal power, all banks idle, mode 0, no burst.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cke | input | 1 | Clock enable |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| ba | input | 2 | Bank select |
| addr | input | 11 | Address; bit 10 is the auto-precharge / all-banks flag |
| cmd_o | output | 4 | Decoded command code |
| cmd_illegal_o | output | 1 | Reported command was rejected |
| pwr_o | output | 2 | Power state: 0 normal, 1 self refresh, 2 power down, 3 clock suspend |
| bank_state_o | output | 8 | Two bits per bank: 0 idle, 1 open, 2 recovering |
| mode_o | output | 13 | Mode register |
| burst_busy_o | output | 1 | A data burst is in progress |

## Verification
Every result is due one rising edge after its inputs are sampled. The bench drives on the falling edge and compares at the next falling edge, so the posedge between them is the only one that counts. The recovery window is counted in edges from the command edge: with the defaults, a write with auto-precharge at burst 1 is refused for exactly four following edges, and the fifth is accepted. The reference model steps once per driven cycle, in the same falling-edge slot, so its expected values always line up with that single edge of latency.

// File: rtl/sdram_trk_pkg.sv
package sdram_trk_pkg;

  typedef enum logic [3:0] {
    CMD_DESEL = 4'd0,
    CMD_NOP   = 4'd1,
    CMD_ACT   = 4'd2,
    CMD_RD    = 4'd3,
    CMD_WR    = 4'd4,
    CMD_PRE   = 4'd5,
    CMD_PREA  = 4'd6,
    CMD_AREF  = 4'd7,
    CMD_SREF  = 4'd8,
    CMD_MRS   = 4'd9,
    CMD_BST   = 4'd10,
    CMD_LOWP  = 4'd11
  } cmd_e;

  typedef enum logic [1:0] {
    PWR_NORM = 2'd0,
    PWR_SELF = 2'd1,
    PWR_PDN  = 2'd2,
    PWR_SUSP = 2'd3
  } pwr_e;

  typedef enum logic [1:0] {
    BK_IDLE = 2'd0,
    BK_OPEN = 2'd1,
    BK_REC  = 2'd2
  } bank_e;

  // beats of a burst from the length code; 0 stands for full page
  function automatic logic [3:0] burst_beats(input logic [2:0] code);
    case (code)
      3'd0:    return 4'd1;
      3'd1:    return 4'd2;
      3'd2:    return 4'd4;
      3'd3:    return 4'd8;
      3'd7:    return 4'd0;
      default: return 4'd1;
    endcase
  endfunction

  // edges a bank stays in recovery after an auto-precharge access
  function automatic int unsigned lockout_edges(input logic [3:0] beats, input logic is_wr,
                                                input int unsigned twr, input int unsigned trp);
    return (int'(beats) - 1) + (is_wr ? twr : 0) + trp;
  endfunction

endpackage

// File: rtl/sdram_cmd_decode.sv
module sdram_cmd_decode
  import sdram_trk_pkg::*;
(
  input  logic cke_prev,
  input  logic cke,
  input  logic cs_n,
  input  logic ras_n,
  input  logic cas_n,
  input  logic we_n,
  input  logic all_bank,
  output cmd_e cmd
);
  logic [2:0] strobes;
  cmd_e       raw;

  assign strobes = {ras_n, cas_n, we_n};

  always_comb begin
    case (strobes)
      3'b000:  raw = CMD_MRS;
      3'b001:  raw = cke ? CMD_AREF : CMD_SREF;
      3'b010:  raw = all_bank ? CMD_PREA : CMD_PRE;
      3'b011:  raw = CMD_ACT;
      3'b100:  raw = CMD_WR;
      3'b101:  raw = CMD_RD;
      3'b110:  raw = CMD_BST;
      default: raw = CMD_NOP;
    endcase
    if (!cke_prev)
      cmd = CMD_LOWP;
    else if (!cke)
      cmd = (!cs_n && raw == CMD_SREF) ? CMD_SREF : CMD_LOWP;
    else if (cs_n)
      cmd = CMD_DESEL;
    else
      cmd = raw;
  end
endmodule

// File: rtl/sdram_bank_slot.sv
module sdram_bank_slot
  import sdram_trk_pkg::*;
#(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             open_i,
  input  logic             close_i,
  input  logic             arm_i,
  input  logic [CNT_W-1:0] arm_len_i,
  output bank_e            state_o
);
  bank_e            st_q;
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q  <= BK_IDLE;
      cnt_q <= '0;
    end else if (st_q == BK_REC) begin
      if (cnt_q <= CNT_W'(1)) st_q <= BK_IDLE;
      else                    cnt_q <= cnt_q - CNT_W'(1);
    end else if (arm_i) begin
      st_q  <= BK_REC;
      cnt_q <= arm_len_i;
    end else if (close_i) begin
      st_q <= BK_IDLE;
    end else if (open_i) begin
      st_q <= BK_OPEN;
    end
  end

  assign state_o = st_q;
endmodule

// File: rtl/sdram_pwr_ctrl.sv
module sdram_pwr_ctrl
  import sdram_trk_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic cke,
  input  logic sref_go,
  input  logic burst_busy,
  output logic cke_prev,
  output pwr_e pwr
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cke_prev <= 1'b1;
      pwr      <= PWR_NORM;
    end else begin
      cke_prev <= cke;
      if (cke_prev && !cke)
        pwr <= sref_go ? PWR_SELF : (burst_busy ? PWR_SUSP : PWR_PDN);
      else if (!cke_prev && cke)
        pwr <= PWR_NORM;
    end
  end
endmodule

// File: rtl/sdram_cmd_tracker.sv
module sdram_cmd_tracker
  import sdram_trk_pkg::*;
#(
  parameter int NB  = 4,
  parameter int AW  = 11,
  parameter int TWR = 2,
  parameter int TRP = 2,
  localparam int BA_W = $clog2(NB),
  localparam int MR_W = BA_W + AW
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cke,
  input  logic            cs_n,
  input  logic            ras_n,
  input  logic            cas_n,
  input  logic            we_n,
  input  logic [BA_W-1:0] ba,
  input  logic [AW-1:0]   addr,
  output logic [3:0]      cmd_o,
  output logic            cmd_illegal_o,
  output logic [1:0]      pwr_o,
  output logic [2*NB-1:0] bank_state_o,
  output logic [MR_W-1:0] mode_o,
  output logic            burst_busy_o
);
  localparam int AP_BIT  = AW - 1;
  localparam int WS_BIT  = 9;
  localparam int CNT_W   = $clog2(8 + TWR + TRP);
  localparam int LEFT_W  = 4;

  cmd_e            cmd;
  pwr_e            pwr;
  logic            cke_prev;
  bank_e           bk [NB];
  logic            all_idle, any_rec, legal;
  bank_e           tgt;
  logic [MR_W-1:0] mode_q;
  logic            mrs_busy_q;
  logic [LEFT_W-1:0] left_q;
  logic            full_q;
  logic [3:0]      rd_beats, wr_beats, acc_beats;
  logic            ev_act, ev_rd, ev_wr, ev_pre, ev_prea, ev_mrs, ev_sref, ap_go;
  logic [CNT_W-1:0] ap_len;
  cmd_e            cmd_q;
  logic            ill_q;

  sdram_cmd_decode u_dec (
    .cke_prev (cke_prev), .cke (cke), .cs_n (cs_n), .ras_n (ras_n),
    .cas_n (cas_n), .we_n (we_n), .all_bank (addr[AP_BIT]), .cmd (cmd)
  );

  always_comb begin
    all_idle = 1'b1;
    any_rec  = 1'b0;
    for (int i = 0; i < NB; i++) begin
      if (bk[i] != BK_IDLE) all_idle = 1'b0;
      if (bk[i] == BK_REC)  any_rec  = 1'b1;
    end
  end

  assign tgt = bk[ba];

  always_comb begin
    case (cmd)
      CMD_ACT:                   legal = (tgt == BK_IDLE) && !mrs_busy_q;
      CMD_RD, CMD_WR:            legal = (tgt == BK_OPEN) && !mrs_busy_q;
      CMD_PRE:                   legal = (tgt != BK_REC);
      CMD_PREA:                  legal = !any_rec;
      CMD_AREF, CMD_SREF, CMD_MRS: legal = all_idle && !mrs_busy_q;
      default:                   legal = 1'b1;
    endcase
  end

  assign ev_act  = legal && cmd == CMD_ACT;
  assign ev_rd   = legal && cmd == CMD_RD;
  assign ev_wr   = legal && cmd == CMD_WR;
  assign ev_pre  = legal && cmd == CMD_PRE;
  assign ev_prea = legal && cmd == CMD_PREA;
  assign ev_mrs  = legal && cmd == CMD_MRS;
  assign ev_sref = legal && cmd == CMD_SREF;

  assign rd_beats  = burst_beats(mode_q[2:0]);
  assign wr_beats  = mode_q[WS_BIT] ? 4'd1 : rd_beats;
  assign acc_beats = ev_wr ? wr_beats : rd_beats;
  assign ap_go     = (ev_rd || ev_wr) && addr[AP_BIT] && (acc_beats != 4'd0);
  assign ap_len    = CNT_W'(lockout_edges(acc_beats, ev_wr, TWR, TRP));

  for (genvar g = 0; g < NB; g++) begin : g_bank
    sdram_bank_slot #(.CNT_W(CNT_W)) u_slot (
      .clk       (clk),
      .rst_n     (rst_n),
      .open_i    (ev_act && ba == BA_W'(g)),
      .close_i   ((ev_pre && ba == BA_W'(g)) || ev_prea),
      .arm_i     (ap_go && ba == BA_W'(g)),
      .arm_len_i (ap_len),
      .state_o   (bk[g])
    );
    assign bank_state_o[2*g +: 2] = bk[g];
  end

  sdram_pwr_ctrl u_pwr (
    .clk (clk), .rst_n (rst_n), .cke (cke), .sref_go (ev_sref),
    .burst_busy (burst_busy_o), .cke_prev (cke_prev), .pwr (pwr)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q     <= '0;
      mrs_busy_q <= 1'b0;
      left_q     <= '0;
      full_q     <= 1'b0;
      cmd_q      <= CMD_DESEL;
      ill_q      <= 1'b0;
    end else begin
      cmd_q      <= cmd;
      ill_q      <= !legal;
      mrs_busy_q <= ev_mrs;
      if (ev_mrs) mode_q <= {ba, addr};
      if (cke_prev && cke) begin
        if (ev_rd || ev_wr) begin
          full_q <= (acc_beats == 4'd0);
          left_q <= (acc_beats == 4'd0) ? '0 : LEFT_W'(acc_beats - 4'd1);
        end else if (cmd == CMD_BST) begin
          full_q <= 1'b0;
          left_q <= '0;
        end else if (left_q != '0) begin
          left_q <= left_q - LEFT_W'(1);
        end
      end
    end
  end

  assign cmd_o         = cmd_q;
  assign cmd_illegal_o = ill_q;
  assign pwr_o         = pwr;
  assign mode_o        = mode_q;
  assign burst_busy_o  = full_q || (left_q != '0);
endmodule

// File: rtl/sdram_cmd_tracker_chk.sv
module sdram_cmd_tracker_chk
  import sdram_trk_pkg::*;
#(
  parameter int NB   = 4,
  parameter int BA_W = 2,
  parameter int MR_W = 13
) (
  input logic            clk,
  input logic            rst_n,
  input logic [3:0]      cmd_o,
  input logic            cmd_illegal_o,
  input logic [1:0]      pwr_o,
  input logic [2*NB-1:0] bank_state_o,
  input logic [MR_W-1:0] mode_o,
  input logic            burst_busy_o,
  input logic            ev_act,
  input logic            ev_mrs,
  input logic [BA_W-1:0] ba
);
  assert_act_on_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ev_act |-> bank_state_o[{ba, 1'b0} +: 2] == 2'd0);

  assert_mrs_all_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ev_mrs |-> bank_state_o == '0);

  assert_mode_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_o != 4'(CMD_MRS) || cmd_illegal_o) |-> mode_o == $past(mode_o));

  for (genvar g = 0; g < NB; g++) begin : g_rec
    assert_rec_to_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
      bank_state_o[2*g +: 2] == 2'd2 |=> bank_state_o[2*g +: 2] != 2'd1);
  end

  assert_suspend_needs_burst_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (pwr_o == 2'd3 && $past(pwr_o) == 2'd0) |-> $past(burst_busy_o));

  assert_self_exit_R7: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_o == 2'd1 |=> (pwr_o == 2'd1 || pwr_o == 2'd0));

  assert_lowpower_nodecode_R8: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_o != 2'd0 |=> cmd_o == 4'(CMD_LOWP));
endmodule

bind sdram_cmd_tracker sdram_cmd_tracker_chk #(.NB(NB), .BA_W(BA_W), .MR_W(MR_W)) u_chk (
  .clk (clk), .rst_n (rst_n), .cmd_o (cmd_o), .cmd_illegal_o (cmd_illegal_o),
  .pwr_o (pwr_o), .bank_state_o (bank_state_o), .mode_o (mode_o),
  .burst_busy_o (burst_busy_o), .ev_act (ev_act), .ev_mrs (ev_mrs), .ba (ba)
);

// File: tb/sdram_cmd_tracker_tb.sv
module sdram_cmd_tracker_tb;
  localparam int TWR = 2;
  localparam int TRP = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cke = 1'b1, cs_n = 1'b1, ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1;
  logic [1:0]  ba = '0;
  logic [10:0] addr = '0;
  logic [3:0]  cmd_o;
  logic        cmd_illegal_o;
  logic [1:0]  pwr_o;
  logic [7:0]  bank_state_o;
  logic [12:0] mode_o;
  logic        burst_busy_o;

  int errors = 0;
  int checks = 0;
  string focus = "R10";

  always #2.5 clk = ~clk;

  sdram_cmd_tracker #(.TWR(TWR), .TRP(TRP)) u_dut (
    .clk (clk), .rst_n (rst_n), .cke (cke), .cs_n (cs_n), .ras_n (ras_n),
    .cas_n (cas_n), .we_n (we_n), .ba (ba), .addr (addr), .cmd_o (cmd_o),
    .cmd_illegal_o (cmd_illegal_o), .pwr_o (pwr_o), .bank_state_o (bank_state_o),
    .mode_o (mode_o), .burst_busy_o (burst_busy_o)
  );

  // reference model state
  int          m_bk[4];
  int          m_rc[4];
  logic [12:0] m_mode = '0;
  int          m_pwr = 0;
  bit          m_ckp = 1'b1;
  int          m_left = 0;
  bit          m_full = 1'b0;
  bit          m_mrsb = 1'b0;
  int          e_cmd = 0;
  bit          e_ill = 1'b0;

  function automatic int beats_of(input logic [2:0] c);
    if (c == 3'd0) return 1;
    if (c == 3'd1) return 2;
    if (c == 3'd2) return 4;
    if (c == 3'd3) return 8;
    if (c == 3'd7) return 0;
    return 1;
  endfunction

  task automatic chk(input string what, input int got, input int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d at %0t", focus, what, got, exp, $time);
    end
  endtask

  task automatic compare();
    int bank_exp;
    bank_exp = 0;
    for (int i = 0; i < 4; i++) bank_exp |= (m_bk[i] << (2 * i));
    chk("cmd (R1)", cmd_o, e_cmd);
    chk("illegal (R2)", cmd_illegal_o, e_ill);
    chk("power (R8)", pwr_o, m_pwr);
    chk("banks (R4)", bank_state_o, bank_exp);
    chk("mode (R6)", mode_o, m_mode);
    chk("burst (R9)", burst_busy_o, (m_full || m_left > 0) ? 1 : 0);
  endtask

  task automatic model(input bit k, input logic [3:0] ctl, input logic [1:0] b, input logic [10:0] a);
    int kind, beats;
    bit ok, allidle, anyrec, busy;
    allidle = 1; anyrec = 0;
    for (int i = 0; i < 4; i++) begin
      if (m_bk[i] != 0) allidle = 0;
      if (m_bk[i] == 2) anyrec = 1;
    end
    busy = m_full || m_left > 0;
    if (!m_ckp) kind = 11;
    else if (ctl[3]) kind = k ? 0 : 11;
    else begin
      case (ctl[2:0])
        3'b000: kind = 9;
        3'b001: kind = k ? 7 : 8;
        3'b010: kind = a[10] ? 6 : 5;
        3'b011: kind = 2;
        3'b100: kind = 4;
        3'b101: kind = 3;
        3'b110: kind = 10;
        default: kind = 1;
      endcase
      if (!k && kind != 8) kind = 11;
    end
    case (kind)
      2:       ok = m_bk[b] == 0 && !m_mrsb;
      3, 4:    ok = m_bk[b] == 1 && !m_mrsb;
      5:       ok = m_bk[b] != 2;
      6:       ok = !anyrec;
      7, 8, 9: ok = allidle && !m_mrsb;
      default: ok = 1;
    endcase
    beats = (kind == 4 && m_mode[9]) ? 1 : beats_of(m_mode[2:0]);
    for (int i = 0; i < 4; i++)
      if (m_bk[i] == 2) begin
        if (m_rc[i] <= 1) m_bk[i] = 0; else m_rc[i]--;
      end
    if (ok) begin
      if (kind == 2) m_bk[b] = 1;
      if (kind == 5) m_bk[b] = 0;
      if (kind == 6) for (int i = 0; i < 4; i++) m_bk[i] = 0;
      if ((kind == 3 || kind == 4) && a[10] && beats != 0) begin
        m_bk[b] = 2;
        m_rc[b] = beats - 1 + (kind == 4 ? TWR : 0) + TRP;
      end
      if (kind == 9) m_mode = {b, a};
    end
    m_mrsb = ok && kind == 9;
    if (m_ckp && k) begin
      if (ok && (kind == 3 || kind == 4)) begin
        m_full = beats == 0;
        m_left = beats == 0 ? 0 : beats - 1;
      end else if (kind == 10) begin
        m_full = 0; m_left = 0;
      end else if (m_left > 0) m_left--;
    end
    if (m_ckp && !k) m_pwr = (kind == 8 && ok) ? 1 : (busy ? 3 : 2);
    else if (!m_ckp && k) m_pwr = 0;
    m_ckp = k;
    e_cmd = kind;
    e_ill = !ok;
  endtask

  task automatic issue(input bit k, input logic [3:0] ctl, input logic [1:0] b, input logic [10:0] a);
    @(negedge clk);
    compare();
    cke = k; {cs_n, ras_n, cas_n, we_n} = ctl; ba = b; addr = a;
    model(k, ctl, b, a);
  endtask

  task automatic nop(input int n);
    for (int i = 0; i < n; i++) issue(1'b1, 4'b0111, 2'd0, 11'd0);
  endtask
  task automatic act(input logic [1:0] b);            issue(1'b1, 4'b0011, b, 11'h05); endtask
  task automatic rd(input logic [1:0] b, input bit ap); issue(1'b1, 4'b0101, b, {ap, 10'h010}); endtask
  task automatic wr(input logic [1:0] b, input bit ap); issue(1'b1, 4'b0100, b, {ap, 10'h020}); endtask
  task automatic pre(input logic [1:0] b, input bit all); issue(1'b1, 4'b0010, b, {all, 10'h0}); endtask
  task automatic mrs(input logic [12:0] v);           issue(1'b1, 4'b0000, v[12:11], v[10:0]); endtask

  initial begin
    for (int i = 0; i < 4; i++) begin m_bk[i] = 0; m_rc[i] = 0; end
    repeat (3) @(negedge clk);
    focus = "R10";
    compare();
    rst_n = 1'b1;
    model(1'b1, 4'b1111, 2'd0, 11'd0);

    focus = "R1";
    nop(2);
    issue(1'b1, 4'b1000, 2'd1, 11'd0);
    issue(1'b1, 4'b0110, 2'd0, 11'd0);

    focus = "R2";
    rd(2'd0, 1'b0);
    act(2'd0);
    act(2'd0);
    rd(2'd0, 1'b0);
    wr(2'd0, 1'b0);
    wr(2'd3, 1'b0);

    focus = "R3";
    pre(2'd0, 1'b0);
    act(2'd1); act(2'd2);
    pre(2'd3, 1'b0);
    pre(2'd0, 1'b1);
    nop(1);

    focus = "R6";
    mrs(13'h002);
    act(2'd0);
    act(2'd0);
    mrs(13'h003);
    pre(2'd0, 1'b0);
    mrs(13'h002);
    nop(1);

    focus = "R4";
    act(2'd1);
    wr(2'd1, 1'b1);
    for (int i = 0; i < 9; i++) act(2'd1);
    pre(2'd1, 1'b1);
    act(2'd2);
    rd(2'd2, 1'b1);
    pre(2'd2, 1'b0);
    for (int i = 0; i < 6; i++) act(2'd2);
    pre(2'd0, 1'b1);
    nop(2);

    focus = "R9";
    mrs(13'h003);
    act(2'd0);
    rd(2'd0, 1'b0);
    nop(3);
    focus = "R8";
    issue(1'b0, 4'b0111, 2'd0, 11'd0);
    issue(1'b0, 4'b0101, 2'd0, 11'd0);
    issue(1'b1, 4'b0111, 2'd0, 11'd0);
    nop(6);
    issue(1'b0, 4'b0111, 2'd0, 11'd0);
    issue(1'b0, 4'b0011, 2'd1, 11'd0);
    issue(1'b1, 4'b0111, 2'd0, 11'd0);
    nop(1);
    pre(2'd0, 1'b1);
    nop(1);

    focus = "R7";
    issue(1'b1, 4'b0001, 2'd0, 11'd0);
    nop(1);
    issue(1'b0, 4'b0001, 2'd0, 11'd0);
    issue(1'b0, 4'b1111, 2'd0, 11'd0);
    issue(1'b1, 4'b1111, 2'd0, 11'd0);
    nop(1);
    act(2'd3);
    issue(1'b0, 4'b0001, 2'd0, 11'd0);
    issue(1'b1, 4'b0111, 2'd0, 11'd0);
    pre(2'd3, 1'b0);
    nop(1);

    focus = "R5";
    mrs(13'h007);
    act(2'd0);
    wr(2'd0, 1'b1);
    nop(4);
    rd(2'd0, 1'b1);
    nop(2);
    issue(1'b1, 4'b0110, 2'd0, 11'd0);
    nop(2);
    pre(2'd0, 1'b1);
    nop(1);

    focus = "R9";
    mrs(13'h203);
    act(2'd2);
    wr(2'd2, 1'b1);
    for (int i = 0; i < 6; i++) act(2'd2);
    pre(2'd0, 1'b1);
    nop(1);

    focus = "R1";
    for (int n = 0; n < 800; n++) begin
      int r;
      logic [1:0] b;
      logic [12:0] mv;
      bit k;
      r = $urandom_range(0, 99);
      b = 2'($urandom_range(0, 3));
      k = (m_pwr != 0) ? ($urandom_range(0, 3) != 0) : ($urandom_range(0, 24) != 0);
      if (!k && m_pwr == 0) issue(1'b0, ($urandom_range(0, 1) != 0) ? 4'b0001 : 4'b0111, b, 11'd0);
      else if (r < 25) act(b);
      else if (r < 40) rd(b, $urandom_range(0, 1) != 0);
      else if (r < 55) wr(b, $urandom_range(0, 1) != 0);
      else if (r < 65) pre(b, 1'b0);
      else if (r < 68) pre(b, 1'b1);
      else if (r < 71) issue(k, 4'b0001, b, 11'd0);
      else if (r < 75) begin
        case ($urandom_range(0, 4))
          0: mv = 13'd0; 1: mv = 13'd1; 2: mv = 13'd2; 3: mv = 13'd3; default: mv = 13'd7;
        endcase
        if ($urandom_range(0, 1) != 0) mv |= 13'h200;
        mrs(mv);
      end
      else if (r < 80) issue(k, 4'b0110, b, 11'd0);
      else issue(k, 4'b0111, b, 11'd0);
    end
    @(negedge clk);
    compare();

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog %s: actual=running expected=finished", focus);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule